// File: doc/BRIEF.md
# Sleep Wake-Up Destination Controller

This block watches a processor's low-power idle state. When the core executes its idle instruction, a one-cycle strobe puts the controller into sleep. While asleep, it screens the interrupt request lines through the interrupt mask and, for sources that need it, a per-source arm bit. The first screened request ends sleep and produces a single registered program-counter load.

The state of the global interrupt enable at the moment of the idle strobe fixes where execution resumes. With the enable set, the core jumps to the vector of the winning source and that source is acknowledged. With the enable clear, the core resumes at the return address captured with the idle strobe, and nothing is acknowledged. Leaving reset always produces a load of the reset vector, whatever the mask, arm and enable settings are. While the core is awake, requests are left to the normal interrupt dispatch path and have no effect here.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: While `rst_ni` is low, `sleep_o`, `wake_o`, `pc_load_o` and `ack_o` are all 0. On the first clock edge after `rst_ni` rises, `wake_o` and `pc_load_o` pulse for one cycle with `pc_o` equal to `reset_vec_i`, `ack_o` = 0 and `sleep_o` = 0.
- R2: When the block is awake and `idle_i` is high at a clock edge, `sleep_o` is 1 from that edge on. An `idle_i` pulse while asleep has no effect on the resume address or the enable captured earlier.
- R3: A source whose `imr_i` bit is 0 never ends sleep.
- R4: A source `k` with bit `k` of parameter `ARM_NEED` set (default 8'hF0, sources 4 to 7) can end sleep only if `arm_i[k]` is 1. Sources whose `ARM_NEED` bit is 0 ignore `arm_i`.
- R5: If `gie_i` was 1 at the idle strobe, a wake loads `pc_o` with the vector of the winning source (slice `k` of `vec_tbl_i`, bits `k*ADDR_W +: ADDR_W`) and sets `ack_o` to a one-hot word at that source.
- R6: If `gie_i` was 0 at the idle strobe, a wake loads `pc_o` with `next_pc_i` as sampled at the idle strobe, and `ack_o` stays 0. Any masked-in source can cause this wake.
- R7: When several eligible requests are present at the wake edge, the lowest-numbered one wins.
- R8: A wake is registered. `wake_o` and `pc_load_o` are high for exactly one cycle, on the clock edge after an eligible request is seen while asleep, and `sleep_o` falls at that same edge.
- R9: While awake, requests cause no `wake_o`, no `pc_load_o` and no `ack_o`.
- R10: Changes to `gie_i` or `next_pc_i` after the idle strobe do not alter the destination of the following wake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; its release forces a reset-vector load |
| idle_i | input | 1 | One-cycle strobe from the idle instruction |
| irq_i | input | N_SRC | Interrupt request lines, source 0 first |
| imr_i | input | N_SRC | Interrupt mask, 1 = source enabled |
| arm_i | input | N_SRC | Sleep visibility arm bits |
| gie_i | input | 1 | Global interrupt enable |
| next_pc_i | input | ADDR_W | Address of the instruction after the idle instruction |
| vec_tbl_i | input | N_SRC*ADDR_W | Vector addresses, source k at bits k*ADDR_W +: ADDR_W |
| reset_vec_i | input | ADDR_W | Reset vector address |
| sleep_o | output | 1 | Core is asleep |
| wake_o | output | 1 | One-cycle wake pulse |
| pc_o | output | ADDR_W | Program counter value to load |
| pc_load_o | output | 1 | Load strobe for `pc_o` |
| ack_o | output | N_SRC | One-hot acknowledge of the serviced source |

## Verification
A corrupted captured enable shows at the very wake edge. `pc_o` carries the return address where a vector was due, or the reverse, and `ack_o` is zero or non-zero against expectation. A stale return register shows up in the same way on the same cycle. A sleep flag stuck high or low appears one edge after the idle strobe, or as a missing wake pulse on the first eligible request. A wrong arbitration or gating term appears as the wrong vector or acknowledge bit in that same cycle, or as a wake that should not have happened. The bench therefore samples every output on the cycle right after each stimulus and sweeps every combination of enable, mask and arm.

// File: rtl/swk_pkg.sv
package swk_pkg;

   // Destination chosen for the program counter on a given cycle
   typedef enum logic [1:0] {
      DST_NONE   = 2'd0,
      DST_RESET  = 2'd1,
      DST_VECTOR = 2'd2,
      DST_RESUME = 2'd3
   } dest_e;

   // Arbiter implementation variants
   localparam int PICK_RIPPLE = 0;
   localparam int PICK_TWOS   = 1;

endpackage

// File: rtl/swk_gate.sv
// Per-source screening: a request is eligible only when masked in, and,
// for sources that need it, armed for visibility during sleep.
module swk_gate #(
   parameter int               N_SRC    = 8,
   parameter logic [N_SRC-1:0] ARM_NEED = '0
) (
   input  logic [N_SRC-1:0] irq_i,
   input  logic [N_SRC-1:0] imr_i,
   input  logic [N_SRC-1:0] arm_i,
   output logic [N_SRC-1:0] elig_o
);

   for (genvar k = 0; k < N_SRC; k++) begin : g_src
      if (ARM_NEED[k]) begin : g_armed
         assign elig_o[k] = irq_i[k] & imr_i[k] & arm_i[k];
      end else begin : g_plain
         assign elig_o[k] = irq_i[k] & imr_i[k];
      end
   end

endmodule

// File: rtl/swk_pick.sv
// Lowest-index-first one-hot selection with two build variants.
module swk_pick
   import swk_pkg::*;
#(
   parameter int N_SRC = 8,
   parameter int STYLE = PICK_RIPPLE
) (
   input  logic [N_SRC-1:0] req_i,
   output logic [N_SRC-1:0] grant_o,
   output logic             any_o
);

   if (STYLE != PICK_RIPPLE && STYLE != PICK_TWOS) begin : g_bad_style
      $error("swk_pick: unsupported STYLE");
   end

   if (STYLE == PICK_RIPPLE) begin : g_ripple
      // seen[k] is high when any request below k is present
      logic [N_SRC:0] seen;
      assign seen[0] = 1'b0;
      for (genvar k = 0; k < N_SRC; k++) begin : g_bit
         assign grant_o[k]  = req_i[k] & ~seen[k];
         assign seen[k+1]   = seen[k] | req_i[k];
      end
   end else begin : g_twos
      // isolate lowest set bit via two's complement
      logic [N_SRC-1:0] neg;
      assign neg     = (~req_i) + {{(N_SRC-1){1'b0}}, 1'b1};
      assign grant_o = req_i & neg;
   end

   assign any_o = |req_i;

endmodule

// File: rtl/swk_vecsel.sv
// AND-OR selection of one vector address from the flat table.
module swk_vecsel #(
   parameter int N_SRC  = 8,
   parameter int ADDR_W = 16
) (
   input  logic [N_SRC-1:0]        grant_i,
   input  logic [N_SRC*ADDR_W-1:0] tbl_i,
   output logic [ADDR_W-1:0]       addr_o
);

   logic [ADDR_W-1:0] part [N_SRC+1];

   assign part[0] = '0;
   for (genvar k = 0; k < N_SRC; k++) begin : g_or
      assign part[k+1] = part[k]
                       | (tbl_i[k*ADDR_W +: ADDR_W] & {ADDR_W{grant_i[k]}});
   end
   assign addr_o = part[N_SRC];

endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
   import swk_pkg::*;
#(
   parameter int               N_SRC      = 8,
   parameter int               ADDR_W     = 16,
   parameter logic [N_SRC-1:0] ARM_NEED   = 8'hF0,
   parameter int               PICK_STYLE = PICK_RIPPLE
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     idle_i,
   input  logic [N_SRC-1:0]         irq_i,
   input  logic [N_SRC-1:0]         imr_i,
   input  logic [N_SRC-1:0]         arm_i,
   input  logic                     gie_i,
   input  logic [ADDR_W-1:0]        next_pc_i,
   input  logic [N_SRC*ADDR_W-1:0]  vec_tbl_i,
   input  logic [ADDR_W-1:0]        reset_vec_i,
   output logic                     sleep_o,
   output logic                     wake_o,
   output logic [ADDR_W-1:0]        pc_o,
   output logic                     pc_load_o,
   output logic [N_SRC-1:0]         ack_o
);

   localparam int TBL_W = N_SRC * ADDR_W;

   if (N_SRC < 1 || N_SRC > 32) begin : g_bad_nsrc
      $error("sleep_wake_ctrl: N_SRC must be 1..32");
   end
   if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_addr
      $error("sleep_wake_ctrl: ADDR_W must be 2..64");
   end
   if (TBL_W != $bits(vec_tbl_i)) begin : g_bad_tbl
      $error("sleep_wake_ctrl: vector table width mismatch");
   end

   // ---------------- state ----------------
   logic              sleep_q;
   logic              boot_q;
   logic              gie_q;
   logic [ADDR_W-1:0] ret_q;
   logic              wake_q;
   logic              load_q;
   logic [ADDR_W-1:0] pc_q;
   logic [N_SRC-1:0]  ack_q;

   // ---------------- datapath ----------------
   logic [N_SRC-1:0]  elig;
   logic [N_SRC-1:0]  grant;
   logic              any_elig;
   logic [ADDR_W-1:0] vec_addr;
   dest_e             dest;

   swk_gate #(
      .N_SRC    (N_SRC),
      .ARM_NEED (ARM_NEED)
   ) u_gate (
      .irq_i  (irq_i),
      .imr_i  (imr_i),
      .arm_i  (arm_i),
      .elig_o (elig)
   );

   swk_pick #(
      .N_SRC (N_SRC),
      .STYLE (PICK_STYLE)
   ) u_pick (
      .req_i   (elig),
      .grant_o (grant),
      .any_o   (any_elig)
   );

   swk_vecsel #(
      .N_SRC  (N_SRC),
      .ADDR_W (ADDR_W)
   ) u_vecsel (
      .grant_i (grant),
      .tbl_i   (vec_tbl_i),
      .addr_o  (vec_addr)
   );

   // Destination decision: reset release outranks everything
   always_comb begin
      if (boot_q) begin
         dest = DST_RESET;
      end else if (sleep_q && any_elig) begin
         dest = gie_q ? DST_VECTOR : DST_RESUME;
      end else begin
         dest = DST_NONE;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sleep_q <= 1'b0;
         boot_q  <= 1'b1;
         gie_q   <= 1'b0;
         ret_q   <= '0;
         wake_q  <= 1'b0;
         load_q  <= 1'b0;
         pc_q    <= '0;
         ack_q   <= '0;
      end else begin
         wake_q <= 1'b0;
         load_q <= 1'b0;
         ack_q  <= '0;
         case (dest)
            DST_RESET: begin
               boot_q  <= 1'b0;
               sleep_q <= 1'b0;
               wake_q  <= 1'b1;
               load_q  <= 1'b1;
               pc_q    <= reset_vec_i;
            end
            DST_VECTOR: begin
               sleep_q <= 1'b0;
               wake_q  <= 1'b1;
               load_q  <= 1'b1;
               pc_q    <= vec_addr;
               ack_q   <= grant;
            end
            DST_RESUME: begin
               sleep_q <= 1'b0;
               wake_q  <= 1'b1;
               load_q  <= 1'b1;
               pc_q    <= ret_q;
            end
            default: begin
               if (!sleep_q && idle_i) begin
                  sleep_q <= 1'b1;
                  gie_q   <= gie_i;
                  ret_q   <= next_pc_i;
               end
            end
         endcase
      end
   end

   assign sleep_o   = sleep_q;
   assign wake_o    = wake_q;
   assign pc_load_o = load_q;
   assign pc_o      = pc_q;
   assign ack_o     = ack_q;

   // ---------------- assertions ----------------
   // R8
   wake_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_o |=> !wake_o);

   // R8
   wake_not_asleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_o |-> (!sleep_o && pc_load_o));

   // R8
   sleep_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sleep_o) |-> wake_o);

   // R2
   sleep_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sleep_o && idle_i && !boot_q) |=> sleep_o);

   // R7
   ack_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(ack_o));

   // R5
   ack_with_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_o != '0) |-> (pc_load_o && wake_o));

   // R9
   no_wake_awake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sleep_o && !boot_q) |=> !wake_o);

   // R3
   mask_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sleep_o && ((irq_i & imr_i) == '0)) |=> !wake_o);

   // R10
   ret_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sleep_o && !wake_o) |=> $stable(ret_q) && $stable(gie_q));

endmodule

// File: tb/sleep_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module sleep_wake_ctrl_tb_top;

   localparam int N   = 8;
   localparam int AW  = 16;
   localparam logic [N-1:0] ARM_NEED = 8'hF0;
   localparam logic [AW-1:0] RST_VEC = 16'hFFF0;

   logic            clk = 1'b0;
   logic            rst_ni;
   logic            idle;
   logic [N-1:0]    irq, imr, arm;
   logic            gie;
   logic [AW-1:0]   next_pc;
   logic [N*AW-1:0] vec_tbl;
   logic            sleep, wake, pc_load;
   logic [AW-1:0]   pc;
   logic [N-1:0]    ack;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   sleep_wake_ctrl #(
      .N_SRC    (N),
      .ADDR_W   (AW),
      .ARM_NEED (ARM_NEED)
   ) dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_ni),
      .idle_i      (idle),
      .irq_i       (irq),
      .imr_i       (imr),
      .arm_i       (arm),
      .gie_i       (gie),
      .next_pc_i   (next_pc),
      .vec_tbl_i   (vec_tbl),
      .reset_vec_i (RST_VEC),
      .sleep_o     (sleep),
      .wake_o      (wake),
      .pc_o        (pc),
      .pc_load_o   (pc_load),
      .ack_o       (ack)
   );

   function automatic logic [AW-1:0] vec_of(int k);
      return 16'h2000 + AW'(k) * 16'h0104;
   endfunction

   function automatic logic [N-1:0] eligible(logic [N-1:0] q, logic [N-1:0] m,
                                             logic [N-1:0] a);
      return q & m & (a | ~ARM_NEED);
   endfunction

   function automatic int lowest(logic [N-1:0] e);
      for (int k = 0; k < N; k++) if (e[k]) return k;
      return -1;
   endfunction

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_ni = 1'b0; idle = 1'b0; irq = '0;
      @(negedge clk);
      chk(!sleep && !wake && !pc_load && ack == '0, "R1 reset state",
          {sleep, wake, pc_load, ack}, 0);
      rst_ni = 1'b1;
      @(negedge clk);
      chk(wake && pc_load && pc == RST_VEC && ack == '0 && !sleep,
          "R1 reset vector", {wake, pc_load, pc}, {2'b11, RST_VEC});
      @(negedge clk);
      chk(!wake && !pc_load, "R8 boot pulse width", {wake, pc_load}, 0);
   endtask

   task automatic enter_sleep(logic g, logic [AW-1:0] npc);
      gie = g; next_pc = npc; idle = 1'b1;
      @(negedge clk);
      idle = 1'b0;
      chk(sleep, "R2 sleep after idle", sleep, 1);
      // R10: scramble after capture
      gie = ~g; next_pc = ~npc;
   endtask

   // apply one request pattern while asleep and check the outcome
   task automatic try_wake(logic g, logic [AW-1:0] npc, logic [N-1:0] q,
                           logic [N-1:0] m, logic [N-1:0] a, string tag);
      logic [N-1:0] e;
      int w;
      e = eligible(q, m, a);
      w = lowest(e);
      irq = q; imr = m; arm = a;
      @(negedge clk);
      irq = '0;
      if (w < 0) begin
         chk(!wake && !pc_load && sleep, {tag, " no wake"},
             {wake, pc_load, sleep}, 1);
         do_reset();
      end else if (g) begin
         chk(wake && pc_load && !sleep && pc == vec_of(w)
             && ack == (N'(1) << w), {tag, " vector"},
             {pc, ack}, {vec_of(w), N'(1) << w});
         @(negedge clk);
         chk(!wake && !pc_load && ack == '0, "R8 wake width", {wake, pc_load}, 0);
      end else begin
         chk(wake && pc_load && !sleep && pc == npc && ack == '0,
             {tag, " resume"}, {pc, ack}, {npc, 8'h00});
         @(negedge clk);
         chk(!wake && !pc_load, "R8 wake width", {wake, pc_load}, 0);
      end
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: actual %h expected %h", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = 32'h5EED_0042;
      void'($urandom(seed));
      for (int k = 0; k < N; k++) vec_tbl[k*AW +: AW] = vec_of(k);
      rst_ni = 1'b0; idle = 1'b0; irq = '0; imr = '0; arm = '0;
      gie = 1'b0; next_pc = '0;
      do_reset();

      // R9: requests while awake do nothing
      irq = '1; imr = '1; arm = '1; gie = 1'b1;
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         chk(!wake && !pc_load && ack == '0 && !sleep, "R9 awake ignore",
             {wake, pc_load, ack}, 0);
      end
      irq = '0;

      // R5 / R6 / R3 / R4: every enable, mask, arm combination on sources 1 and 5
      for (int s = 0; s < 2; s++) begin
         for (int c = 0; c < 8; c++) begin
            int src;
            src = (s == 0) ? 1 : 5;
            enter_sleep(c[2], 16'h0300 + AW'(c));
            try_wake(c[2], 16'h0300 + AW'(c), N'(1) << src,
                     c[1] ? (N'(1) << src) : '0,
                     c[0] ? (N'(1) << src) : '0,
                     c[1] ? (c[0] || src < 4 ? "R5R6R4 combo" : "R4 unarmed")
                          : "R3 masked");
         end
      end

      // R7: several requests, lowest wins
      enter_sleep(1'b1, 16'h0444);
      try_wake(1'b1, 16'h0444, 8'b1010_0100, '1, '1, "R7 priority");

      // R6: hold sleep, any masked-in source wakes to resume point
      enter_sleep(1'b0, 16'h0555);
      try_wake(1'b0, 16'h0555, 8'b1000_0000, 8'b1000_0000, 8'b1000_0000, "R6 hold");

      // R2: idle pulse while asleep does not recapture
      enter_sleep(1'b1, 16'h0666);
      idle = 1'b1; gie = 1'b0; next_pc = 16'h0777;
      @(negedge clk);
      idle = 1'b0;
      chk(sleep && !wake, "R2 idle while asleep", {sleep, wake}, 2'b10);
      try_wake(1'b1, 16'h0666, 8'h08, 8'h08, 8'h00, "R2 recapture");

      // R1: reset during sleep overrides everything
      enter_sleep(1'b1, 16'h0888);
      do_reset();

      // random mix
      for (int i = 0; i < 300; i++) begin
         logic            g;
         logic [AW-1:0]   npc;
         logic [N-1:0]    q, m, a;
         g   = 1'($urandom);
         npc = AW'($urandom);
         q   = N'($urandom) | N'($urandom);
         m   = N'($urandom) | N'($urandom);
         a   = N'($urandom);
         enter_sleep(g, npc);
         if (i % 3 == 0) begin
            @(negedge clk);
            chk(sleep && !wake, "R10 idle hold", {sleep, wake}, 2'b10);
         end
         try_wake(g, npc, q, m, a, "R5R6R7 random");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule